// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level translation table from memory. A one-cycle start pulse captures the virtual address, the table base and a configuration bit that allows fine second-level tables. The walker then fetches the first-level entry through a single-word read port. Depending on the kind of entry, it either finishes at once (a section or a fault) or fetches one second-level entry from a coarse or a fine table.

When the walk ends, the walker raises a one-cycle completion pulse. At the same time it presents the physical address, a 2-bit page kind, the cacheable/bufferable pair, the domain, the access-permission field and a fault flag. These outputs hold until the next walk completes. Only one walk is in progress at a time, and no results are kept between walks.

Top module: `xlat_walker`

## Requirements
- R1: The first read goes to address {base[31:14], va[31:20], 2'b00}. Base bits [13:0] have no effect.
- R2: A first-level entry whose bits [1:0] are 00 ends the walk with the fault flag set, after exactly one read.
- R3: A first-level entry with bits [1:0] = 11 (fine table) ends the walk with a fault after one read when the tiny-enable bit captured at start is 0.
- R4: A first-level entry with bits [1:0] = 10 (section) ends the walk after one read. It gives pa = {d[31:20], va[19:0]}, page kind 0, cb = d[3:2] and ap = {6'b0, d[11:10]}.
- R5: A first-level entry with bits [1:0] = 01 (coarse) causes a second read at {d[31:10], va[19:12], 2'b00}.
- R6: A first-level entry with bits [1:0] = 11 and tiny enabled causes a second read at {d[31:12], va[19:10], 2'b00}.
- R7: A second-level entry with bits [1:0] = 00 ends the walk with the fault flag set.
- R8: Second-level bits [1:0] select the page: 01 is large, with page kind 1 and pa = {e[31:16], va[15:0]}. 10 is small, with page kind 2 and pa = {e[31:12], va[11:0]}. 11 is tiny, with page kind 3 and pa = {e[31:10], va[9:0]}.
- R9: For second-level pages, cb = e[3:2]. ap = e[11:4] for large and small pages and {6'b0, e[5:4]} for tiny pages. For every non-fault result, the domain comes from first-level bits [8:5].
- R10: A read request stays asserted with a stable, word-aligned address until granted. Read data is taken in the grant cycle. There is at most one read outstanding and at most two reads per walk.
- R11: The completion output is high for exactly one cycle per walk, whether the walk succeeds or faults, and never together with a read request.
- R12: A start pulse that arrives during a walk has no effect on that walk's reads or results.
- R13: A synchronous active-high reset returns the walker to idle, with no request and no completion pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle walk request, accepted only when idle |
| vaddr_i | input | 32 | Virtual address, captured on an accepted start |
| tbase_i | input | 32 | Table base, bits [31:14] used |
| tiny_en_i | input | 1 | Allows fine second-level tables when 1 |
| mem_req_o | output | 1 | Read request, held until granted |
| mem_addr_o | output | 32 | Word address of the read |
| mem_gnt_i | input | 1 | Grant, with read data valid in the same cycle |
| mem_rdata_i | input | 32 | Descriptor read data |
| done_o | output | 1 | One-cycle walk completion pulse |
| fault_o | output | 1 | Translation fault for the last walk |
| paddr_o | output | 32 | Physical address |
| ptype_o | output | 2 | Page kind: 0 section, 1 large, 2 small, 3 tiny |
| cb_o | output | 2 | Cacheable/bufferable bits |
| domain_o | output | 4 | Domain from the first-level entry |
| ap_o | output | 8 | Access-permission field |

## Verification
The bench sweeps every first-level kind and every second-level kind, with tiny pages both allowed and forbidden. Each combination runs with virtual addresses that stress the all-ones and mixed-index cases, with a table base whose unused low bits are set, and with grant delays of zero to two cycles. The address of each read shows whether the coarse and fine index slices are placed correctly. The result fields show whether each page size splices its own boundary and picks its own permission width. The delayed grants show whether requests are held stable. A spurious start during every walk, and a reset in the middle of a walk, show that the walker ignores starts while busy and recovers to idle.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int XW     = 32;
    localparam int DOM_W  = 4;
    localparam int CB_W   = 2;
    localparam int AP_W   = 8;
    localparam int BASE_LSB    = 14;
    localparam int SECT_LSB    = 20;
    localparam int LARGE_LSB   = 16;
    localparam int SMALL_LSB   = 12;
    localparam int TINY_LSB    = 10;
    localparam int BASE_W      = XW - BASE_LSB;

    typedef enum logic [1:0] {
        L1K_FAULT   = 2'b00,
        L1K_COARSE  = 2'b01,
        L1K_SECTION = 2'b10,
        L1K_FINE    = 2'b11
    } l1_kind_e;

    typedef enum logic [1:0] {
        L2K_FAULT = 2'b00,
        L2K_LARGE = 2'b01,
        L2K_SMALL = 2'b10,
        L2K_TINY  = 2'b11
    } l2_kind_e;

    typedef enum logic [1:0] {
        PG_SECTION = 2'd0,
        PG_LARGE   = 2'd1,
        PG_SMALL   = 2'd2,
        PG_TINY    = 2'd3
    } page_e;

    typedef enum logic [1:0] {
        WS_IDLE,
        WS_L1,
        WS_L2
    } walk_st_e;

    typedef struct packed {
        logic              fault;
        logic [XW-1:0]     pa;
        page_e             ptype;
        logic [CB_W-1:0]   cb;
        logic [DOM_W-1:0]  dom;
        logic [AP_W-1:0]   ap;
    } xlat_res_t;

    typedef struct packed {
        logic              leaf;
        logic [XW-1:0]     next_addr;
        xlat_res_t         res;
    } l1_dec_t;

    // Keep the upper bits of hi from bit lsb upward, the lower bits from lo.
    function automatic logic [XW-1:0] splice(input logic [XW-1:0] hi,
                                             input logic [XW-1:0] lo,
                                             input int unsigned   lsb);
        logic [XW-1:0] mask;
        mask = {XW{1'b1}} << lsb;
        return (hi & mask) | (lo & ~mask);
    endfunction

    function automatic logic [XW-1:0] l1_entry_addr(input logic [BASE_W-1:0] base,
                                                    input logic [XW-1:0]     va);
        return {base, va[31:20], 2'b00};
    endfunction

    function automatic logic [XW-1:0] coarse_entry_addr(input logic [XW-1:0] d,
                                                        input logic [XW-1:0] va);
        return {d[31:10], va[19:12], 2'b00};
    endfunction

    function automatic logic [XW-1:0] fine_entry_addr(input logic [XW-1:0] d,
                                                      input logic [XW-1:0] va);
        return {d[31:12], va[19:10], 2'b00};
    endfunction

endpackage

// File: rtl/xlat_l1_decode.sv
module xlat_l1_decode
    import xlat_pkg::*;
(
    input  logic [XW-1:0] desc_i,
    input  logic [XW-1:0] va_i,
    input  logic          tiny_en_i,
    output l1_dec_t       dec_o
);

    logic unused_l1_bits;
    assign unused_l1_bits = desc_i[9] ^ desc_i[4];

    always_comb begin
        dec_o           = '0;
        dec_o.res.dom   = desc_i[8:5];
        dec_o.res.cb    = desc_i[3:2];
        dec_o.res.ap    = {{(AP_W-2){1'b0}}, desc_i[11:10]};
        dec_o.res.ptype = PG_SECTION;
        dec_o.res.pa    = splice(desc_i, va_i, SECT_LSB);
        case (l1_kind_e'(desc_i[1:0]))
            L1K_FAULT: begin
                dec_o.leaf      = 1'b1;
                dec_o.res.fault = 1'b1;
            end
            L1K_SECTION: begin
                dec_o.leaf = 1'b1;
            end
            L1K_COARSE: begin
                dec_o.next_addr = coarse_entry_addr(desc_i, va_i);
            end
            default: begin
                if (!tiny_en_i) begin
                    dec_o.leaf      = 1'b1;
                    dec_o.res.fault = 1'b1;
                end else begin
                    dec_o.next_addr = fine_entry_addr(desc_i, va_i);
                end
            end
        endcase
    end

endmodule

// File: rtl/xlat_l2_decode.sv
module xlat_l2_decode
    import xlat_pkg::*;
(
    input  logic [XW-1:0]    desc_i,
    input  logic [XW-1:0]    va_i,
    input  logic [DOM_W-1:0] dom_i,
    output xlat_res_t        res_o
);

    always_comb begin
        res_o       = '0;
        res_o.dom   = dom_i;
        res_o.cb    = desc_i[3:2];
        res_o.ap    = desc_i[11:4];
        case (l2_kind_e'(desc_i[1:0]))
            L2K_FAULT: begin
                res_o.fault = 1'b1;
                res_o.ptype = PG_LARGE;
                res_o.pa    = desc_i;
            end
            L2K_LARGE: begin
                res_o.ptype = PG_LARGE;
                res_o.pa    = splice(desc_i, va_i, LARGE_LSB);
            end
            L2K_SMALL: begin
                res_o.ptype = PG_SMALL;
                res_o.pa    = splice(desc_i, va_i, SMALL_LSB);
            end
            default: begin
                res_o.ptype = PG_TINY;
                res_o.pa    = splice(desc_i, va_i, TINY_LSB);
                res_o.ap    = {{(AP_W-2){1'b0}}, desc_i[5:4]};
            end
        endcase
    end

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
    import xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [XW-1:0]    vaddr_i,
    input  logic [XW-1:0]    tbase_i,
    input  logic             tiny_en_i,
    output logic             mem_req_o,
    output logic [XW-1:0]    mem_addr_o,
    input  logic             mem_gnt_i,
    input  logic [XW-1:0]    mem_rdata_i,
    output logic             done_o,
    output logic             fault_o,
    output logic [XW-1:0]    paddr_o,
    output logic [1:0]       ptype_o,
    output logic [CB_W-1:0]  cb_o,
    output logic [DOM_W-1:0] domain_o,
    output logic [AP_W-1:0]  ap_o
);

    walk_st_e          state_q;
    logic [XW-1:0]     va_q;
    logic [BASE_W-1:0] base_q;
    logic              tiny_q;
    logic [XW-1:0]     l2a_q;
    logic [DOM_W-1:0]  dom_q;
    logic              done_q;
    xlat_res_t         res_q;

    l1_dec_t           l1_dec;
    xlat_res_t         l2_res;

    logic unused_tb_bits;
    assign unused_tb_bits = ^tbase_i[BASE_LSB-1:0];

    xlat_l1_decode i_l1 (
        .desc_i    (mem_rdata_i),
        .va_i      (va_q),
        .tiny_en_i (tiny_q),
        .dec_o     (l1_dec)
    );

    xlat_l2_decode i_l2 (
        .desc_i (mem_rdata_i),
        .va_i   (va_q),
        .dom_i  (dom_q),
        .res_o  (l2_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WS_IDLE;
            va_q    <= '0;
            base_q  <= '0;
            tiny_q  <= 1'b0;
            l2a_q   <= '0;
            dom_q   <= '0;
            done_q  <= 1'b0;
            res_q   <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                WS_IDLE: begin
                    if (start_i) begin
                        va_q    <= vaddr_i;
                        base_q  <= tbase_i[XW-1:BASE_LSB];
                        tiny_q  <= tiny_en_i;
                        state_q <= WS_L1;
                    end
                end
                WS_L1: begin
                    if (mem_gnt_i) begin
                        if (l1_dec.leaf) begin
                            res_q   <= l1_dec.res;
                            done_q  <= 1'b1;
                            state_q <= WS_IDLE;
                        end else begin
                            l2a_q   <= l1_dec.next_addr;
                            dom_q   <= l1_dec.res.dom;
                            state_q <= WS_L2;
                        end
                    end
                end
                WS_L2: begin
                    if (mem_gnt_i) begin
                        res_q   <= l2_res;
                        done_q  <= 1'b1;
                        state_q <= WS_IDLE;
                    end
                end
                default: state_q <= WS_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req_o  = (state_q != WS_IDLE);
        mem_addr_o = (state_q == WS_L2) ? l2a_q : l1_entry_addr(base_q, va_q);
    end

    assign done_o   = done_q;
    assign fault_o  = res_q.fault;
    assign paddr_o  = res_q.pa;
    assign ptype_o  = res_q.ptype;
    assign cb_o     = res_q.cb;
    assign domain_o = res_q.dom;
    assign ap_o     = res_q.ap;

endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk
    import xlat_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          mem_req_o,
    input logic          mem_gnt_i,
    input logic [XW-1:0] mem_addr_o,
    input logic          done_o
);

    logic [1:0] gnt_cnt;

    always_ff @(posedge clk) begin
        if (rst || done_o) begin
            gnt_cnt <= '0;
        end else if (mem_req_o && mem_gnt_i && gnt_cnt != 2'd3) begin
            gnt_cnt <= gnt_cnt + 2'd1;
        end
    end

    assert_req_held_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o)));

    assert_word_aligned_R10: assert property (@(posedge clk) disable iff (rst)
        mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

    assert_reads_per_walk_R10: assert property (@(posedge clk) disable iff (rst)
        gnt_cnt <= 2'd2);

    assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_done_no_req_R11: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !mem_req_o);

endmodule

bind xlat_walker xlat_walker_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .mem_req_o  (mem_req_o),
    .mem_gnt_i  (mem_gnt_i),
    .mem_addr_o (mem_addr_o),
    .done_o     (done_o)
);

// File: tb/test_xlat_walker.sv
`timescale 1ns/1ps
module test_xlat_walker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] vaddr_i = '0;
    logic [31:0] tbase_i = '0;
    logic        tiny_en_i = 1'b0;
    logic        mem_req_o;
    logic [31:0] mem_addr_o;
    logic        mem_gnt_i = 1'b0;
    logic [31:0] mem_rdata_i = '0;
    logic        done_o;
    logic        fault_o;
    logic [31:0] paddr_o;
    logic [1:0]  ptype_o;
    logic [1:0]  cb_o;
    logic [3:0]  domain_o;
    logic [7:0]  ap_o;

    int checks = 0;
    int fails  = 0;
    logic [31:0] mem [logic [31:0]];

    always #2.5 clk = ~clk;

    xlat_walker i_xlat_walker (
        .clk(clk), .rst(rst), .start_i(start_i), .vaddr_i(vaddr_i),
        .tbase_i(tbase_i), .tiny_en_i(tiny_en_i), .mem_req_o(mem_req_o),
        .mem_addr_o(mem_addr_o), .mem_gnt_i(mem_gnt_i), .mem_rdata_i(mem_rdata_i),
        .done_o(done_o), .fault_o(fault_o), .paddr_o(paddr_o), .ptype_o(ptype_o),
        .cb_o(cb_o), .domain_o(domain_o), .ap_o(ap_o)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic run_case(input logic [31:0] va, input logic [31:0] tb,
                            input bit tiny, input int t1, input int t2,
                            input int dl, input int vi);
        logic [31:0] d1, d2, l1a, l2a, held, epa, eap, ecb, edom, eptype;
        int  n, reads, wc;
        bit  efault, gotd;
        string ftag;
        d1  = ((32'h9E5A_B3F0 ^ (vi << 7) ^ (t2 << 21) ^ (dl << 10)) & ~32'h3) | t1;
        d2  = ((32'h6B1D_47CC ^ (vi << 11) ^ (t1 << 5) ^ (dl << 16)) & ~32'h3) | t2;
        l1a = (tb & 32'hFFFF_C000) | ((va >> 18) & 32'h0000_3FFC);
        l2a = (t1 == 1) ? ((d1 & 32'hFFFF_FC00) | ((va >> 10) & 32'h0000_03FC))
                        : ((d1 & 32'hFFFF_F000) | ((va >> 8)  & 32'h0000_0FFC));
        n = (t1 == 1 || (t1 == 3 && tiny)) ? 2 : 1;
        efault = (t1 == 0) || (t1 == 3 && !tiny) || (n == 2 && t2 == 0);
        ftag = (t1 == 0) ? "R2" : (n == 1) ? "R3" : "R7";
        edom = (d1 >> 5) & 32'hF;
        if (n == 1) begin
            epa = (d1 & 32'hFFF0_0000) | (va & 32'h000F_FFFF);
            ecb = (d1 >> 2) & 32'h3; eap = (d1 >> 10) & 32'h3; eptype = 0;
        end else begin
            ecb = (d2 >> 2) & 32'h3;
            eap = (t2 == 3) ? ((d2 >> 4) & 32'h3) : ((d2 >> 4) & 32'hFF);
            eptype = t2;
            case (t2)
                1:       epa = (d2 & 32'hFFFF_0000) | (va & 32'h0000_FFFF);
                2:       epa = (d2 & 32'hFFFF_F000) | (va & 32'h0000_0FFF);
                default: epa = (d2 & 32'hFFFF_FC00) | (va & 32'h0000_03FF);
            endcase
        end
        mem.delete();
        mem[l1a] = d1;
        if (n == 2) mem[l2a] = d2;

        vaddr_i = va; tbase_i = tb; tiny_en_i = tiny; start_i = 1'b1;
        @(negedge clk);
        // R12: a second start with other inputs while the walk is busy
        vaddr_i = ~va; tbase_i = ~tb; tiny_en_i = ~tiny; start_i = 1'b1;
        reads = 0; wc = 0; gotd = 1'b0; held = '0;
        for (int cyc = 0; cyc < 60 && !gotd; cyc++) begin
            if (cyc == 1) start_i = 1'b0;
            mem_gnt_i = 1'b0;
            if (done_o) begin
                gotd = 1'b1;
            end else if (mem_req_o) begin
                if (wc > 0) chk(mem_addr_o == held, "R10 held address", mem_addr_o, held);
                held = mem_addr_o;
                if (wc == dl) begin
                    mem_gnt_i   = 1'b1;
                    mem_rdata_i = mem.exists(mem_addr_o) ? mem[mem_addr_o] : 32'h0;
                    if (reads == 0)
                        chk(mem_addr_o == l1a, "R1 R12 first read address", mem_addr_o, l1a);
                    else
                        chk(mem_addr_o == l2a, (t1 == 1) ? "R5 coarse address" : "R6 fine address",
                            mem_addr_o, l2a);
                    reads++;
                    wc = 0;
                end else begin
                    wc++;
                end
            end
            if (!gotd) @(negedge clk);
        end
        start_i = 1'b0; mem_gnt_i = 1'b0;
        chk(gotd, "R11 completion seen", 32'(gotd), 32'd1);
        chk(reads == n, "R2 R3 R10 read count", reads, n);
        chk(fault_o == efault, efault ? ftag : "R4 R8 no fault", 32'(fault_o), 32'(efault));
        if (!efault) begin
            chk(paddr_o == epa, (n == 1) ? "R4 section pa" : "R8 page pa", paddr_o, epa);
            chk(ptype_o == eptype[1:0], (n == 1) ? "R4 kind" : "R8 kind", 32'(ptype_o), eptype);
            chk(cb_o == ecb[1:0], (n == 1) ? "R4 cb" : "R9 cb", 32'(cb_o), ecb);
            chk(ap_o == eap[7:0], (n == 1) ? "R4 ap" : "R9 ap", 32'(ap_o), eap);
            chk(domain_o == edom[3:0], "R9 domain", 32'(domain_o), edom);
        end
        @(negedge clk);
        chk(!done_o, "R11 one-cycle pulse", 32'(done_o), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] vas [3];
        logic [31:0] tbs [2];
        vas[0] = 32'h1234_5678; vas[1] = 32'hFFFF_FFFF; vas[2] = 32'hA5F0_0C3D;
        tbs[0] = 32'h8000_3FFF; tbs[1] = 32'h0012_C000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!mem_req_o, "R13 no request after reset", 32'(mem_req_o), 32'd0);
        chk(!done_o,    "R13 no completion after reset", 32'(done_o), 32'd0);
        chk(!fault_o,   "R13 fault clear after reset", 32'(fault_o), 32'd0);

        for (int vi = 0; vi < 3; vi++)
            for (int ti = 0; ti < 2; ti++)
                for (int t1 = 0; t1 < 4; t1++)
                    for (int tn = 0; tn < 2; tn++)
                        for (int t2 = 0; t2 < 4; t2++)
                            for (int dl = 0; dl < 3; dl++)
                                run_case(vas[vi], tbs[ti], tn[0], t1, t2, dl, vi);

        // R13: reset in the middle of a walk
        mem.delete();
        vaddr_i = 32'h0040_1000; tbase_i = 32'h0000_4000; tiny_en_i = 1'b1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(mem_req_o, "R13 walk started", 32'(mem_req_o), 32'd1);
        rst = 1'b1;
        @(negedge clk);
        chk(!mem_req_o, "R13 reset drops request", 32'(mem_req_o), 32'd0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(!mem_req_o && !done_o, "R13 stays idle", {30'd0, mem_req_o, done_o}, 32'd0);

        summary();
        $finish;
    end

endmodule